// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds subroutine return addresses for a processor core. It has 31 storage words of 21 bits and a 5-bit pointer. A call pushes the current program counter. A return pops the most recent address. Software can also read or rewrite the top entry directly, load the pointer, and discard the top entry without using it. Pointer value 0 means the stack is empty, and no storage word sits behind it. The valid entries are the words at positions 1 through 31.

Two sticky flags record overflow and underflow. Two configuration inputs decide whether each of those events also raises a one-cycle reset request for the rest of the chip. Without that request, overflow saturates: the pointer stays at 31 and entry 31 is never overwritten. An empty pop returns zero and leaves the pointer at 0. The flags are cleared only by reset or by a software flag write. The polarity of that write is chosen by a parameter. If a hardware set and a software clear land in the same cycle, the set wins.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the pointer is 0, both flags are 0, the reset request is 0 and `topAddr` reads 0.
- R2: A push while the pointer is below 30 moves the pointer up by one and stores `pushPc` at the new position. From the next cycle `topAddr` shows that value.
- R3: During a pop with a non-empty stack, `topAddr` presents the entry at the current pointer in that same cycle, and the pointer drops by one at the clock edge.
- R4: A discard (`dropReq`) with a non-empty stack lowers the pointer by one. After it, `topAddr` shows the entry below the one discarded.
- R5: When overflow reset is enabled, a push at pointer 30 stores its value in entry 31, sets the overflow flag, and forces the pointer to 0. `resetReq` is 1 for exactly the following cycle.
- R6: When overflow reset is disabled, a push at pointer 30 leaves the pointer at 31 and sets the overflow flag. A push at pointer 31 changes neither the pointer nor entry 31, and `resetReq` stays 0.
- R7: A pop or a discard at pointer 0 gives `topAddr` = 0, sets the underflow flag and leaves the pointer at 0. `resetReq` pulses the next cycle only if underflow reset is enabled.
- R8: Both flags are sticky and are cleared only by reset or a flag write. `flagWrData` bit 0 selects overflow and bit 1 selects underflow. With the default `CLR_ON_ONE`=0, writing a 0 clears the bit and writing a 1 leaves it unchanged. A hardware set in the same cycle as a clear keeps the flag at 1.
- R9: A pointer write loads `ptrWrData` (0 to 31) into the pointer. The entries themselves are untouched.
- R10: A top write replaces the entry at the current pointer. At pointer 0 the write is ignored and `topAddr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| cfgOvfRst | input | 1 | Overflow raises a reset request |
| cfgUnfRst | input | 1 | Underflow raises a reset request |
| pushReq | input | 1 | Push `pushPc` |
| pushPc | input | 21 | Return address to push |
| popReq | input | 1 | Pop the top entry (value on `topAddr`) |
| dropReq | input | 1 | Discard the top entry |
| tosWrEn | input | 1 | Overwrite the top entry |
| tosWrData | input | 21 | Data for the top write |
| ptrWrEn | input | 1 | Load the pointer |
| ptrWrData | input | 5 | New pointer value |
| flagWrEn | input | 1 | Software flag write |
| flagWrData | input | 2 | bit0 overflow, bit1 underflow |
| topAddr | output | 21 | Entry at the pointer, 0 when empty |
| stkPtr | output | 5 | Current pointer |
| ovfFlag | output | 1 | Sticky overflow flag |
| unfFlag | output | 1 | Sticky underflow flag |
| resetReq | output | 1 | One-cycle reset request |

## Verification
The assertions assume that in any cycle at most one of push, pop, discard, top write and pointer write is active. They also assume that configuration inputs are steady around a command. A flag write may coincide with any command. The bench issues commands one cycle at a time and changes configuration only between commands. It deliberately pairs a flag clear with an empty pop to exercise set-over-clear priority.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef struct packed {
    logic ptrInc;
    logic ptrDec;
    logic ptrZero;
    logic ptrLoad;
    logic wrNext;
    logic wrCur;
    logic setOvf;
    logic setUnf;
  } rasStrobe_t;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgOvfRst,
  input  logic             cfgUnfRst,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             dropReq,
  input  logic             tosWrEn,
  input  logic             ptrWrEn,
  input  logic [PTR_W-1:0] ptr,
  output rasStrobe_t       stb,
  output logic             resetReq
);
  localparam logic [PTR_W-1:0] TOP_IDX  = '1;
  localparam logic [PTR_W-1:0] NEAR_IDX = TOP_IDX - 1'b1;

  logic isEmpty, isFull, isNear, rstNext;

  assign isEmpty = (ptr == '0);
  assign isFull  = (ptr == TOP_IDX);
  assign isNear  = (ptr == NEAR_IDX);

  always_comb begin
    stb     = '0;
    rstNext = 1'b0;
    if (pushReq) begin
      if (isFull) begin
        stb.setOvf = 1'b1;
        if (cfgOvfRst) begin
          stb.ptrZero = 1'b1;
          rstNext     = 1'b1;
        end
      end else begin
        stb.wrNext = 1'b1;
        if (isNear) begin
          stb.setOvf = 1'b1;
          if (cfgOvfRst) begin
            stb.ptrZero = 1'b1;
            rstNext     = 1'b1;
          end else begin
            stb.ptrInc = 1'b1;
          end
        end else begin
          stb.ptrInc = 1'b1;
        end
      end
    end else if (popReq || dropReq) begin
      if (isEmpty) begin
        stb.setUnf = 1'b1;
        rstNext    = cfgUnfRst;
      end else begin
        stb.ptrDec = 1'b1;
      end
    end else if (tosWrEn) begin
      stb.wrCur = !isEmpty;
    end else if (ptrWrEn) begin
      stb.ptrLoad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= rstNext;
  end

  AST_SINGLE_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.ptrInc, stb.ptrDec, stb.ptrZero, stb.ptrLoad}) <= 1); // R2
  AST_NO_EMPTY_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && isEmpty) |-> !stb.ptrDec); // R7
endmodule

// File: rtl/ras_dp.sv
module ras_dp
  import ras_pkg::*;
#(
  parameter int PTR_W      = 5,
  parameter int DATA_W     = 21,
  parameter bit CLR_ON_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasStrobe_t        stb,
  input  logic [DATA_W-1:0] pushPc,
  input  logic [DATA_W-1:0] tosWrData,
  input  logic [PTR_W-1:0]  ptrWrData,
  input  logic              flagWrEn,
  input  logic [1:0]        flagWrData,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] topData,
  output logic              ovfFlag,
  output logic              unfFlag
);
  localparam int DEPTH = (1 << PTR_W) - 1;

  logic [DATA_W-1:0] mem [1:DEPTH];
  logic [PTR_W-1:0]  nextIdx;
  logic [1:0]        swClr;

  assign nextIdx = ptr + 1'b1;
  assign topData = (ptr == '0) ? '0 : mem[ptr];

  always_ff @(posedge clk) begin
    if (stb.wrNext)     mem[nextIdx] <= pushPc;
    else if (stb.wrCur) mem[ptr]     <= tosWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptr <= '0;
    else if (stb.ptrLoad) ptr <= ptrWrData;
    else if (stb.ptrZero) ptr <= '0;
    else if (stb.ptrInc)  ptr <= nextIdx;
    else if (stb.ptrDec)  ptr <= ptr - 1'b1;
  end

  generate
    if (CLR_ON_ONE) begin : gClrOne
      assign swClr = {2{flagWrEn}} & flagWrData;
    end else begin : gClrZero
      assign swClr = {2{flagWrEn}} & ~flagWrData;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      if (stb.setOvf)    ovfFlag <= 1'b1;
      else if (swClr[0]) ovfFlag <= 1'b0;
      if (stb.setUnf)    unfFlag <= 1'b1;
      else if (swClr[1]) unfFlag <= 1'b0;
    end
  end

  AST_WR_CUR_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCur |-> (ptr != '0)); // R10
  AST_WR_NEXT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrNext |-> (nextIdx != '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.setUnf |=> unfFlag); // R8
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int PTR_W      = 5,
  parameter int DATA_W     = 21,
  parameter bit CLR_ON_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgOvfRst,
  input  logic              cfgUnfRst,
  input  logic              pushReq,
  input  logic [DATA_W-1:0] pushPc,
  input  logic              popReq,
  input  logic              dropReq,
  input  logic              tosWrEn,
  input  logic [DATA_W-1:0] tosWrData,
  input  logic              ptrWrEn,
  input  logic [PTR_W-1:0]  ptrWrData,
  input  logic              flagWrEn,
  input  logic [1:0]        flagWrData,
  output logic [DATA_W-1:0] topAddr,
  output logic [PTR_W-1:0]  stkPtr,
  output logic              ovfFlag,
  output logic              unfFlag,
  output logic              resetReq
);
  localparam logic [PTR_W-1:0] TOP_IDX  = '1;
  localparam logic [PTR_W-1:0] NEAR_IDX = TOP_IDX - 1'b1;

  rasStrobe_t stb;

  ras_ctrl #(.PTR_W(PTR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgOvfRst(cfgOvfRst), .cfgUnfRst(cfgUnfRst),
    .pushReq(pushReq), .popReq(popReq), .dropReq(dropReq),
    .tosWrEn(tosWrEn), .ptrWrEn(ptrWrEn), .ptr(stkPtr),
    .stb(stb), .resetReq(resetReq)
  );

  ras_dp #(.PTR_W(PTR_W), .DATA_W(DATA_W), .CLR_ON_ONE(CLR_ON_ONE)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .pushPc(pushPc),
    .tosWrData(tosWrData), .ptrWrData(ptrWrData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .ptr(stkPtr), .topData(topAddr), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $countones({pushReq, popReq, dropReq, tosWrEn, ptrWrEn}) <= 1); // R9
  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && stkPtr < NEAR_IDX) |=> (stkPtr - $past(stkPtr)) == PTR_W'(1)); // R2
  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && stkPtr < NEAR_IDX) |=> topAddr == $past(pushPc)); // R2
  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rstN)
    ((popReq || dropReq) && stkPtr != '0) |=> ($past(stkPtr) - stkPtr) == PTR_W'(1)); // R3
  AST_OVF_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && cfgOvfRst && stkPtr == NEAR_IDX) |=> (ovfFlag && resetReq && stkPtr == '0)); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !cfgOvfRst && stkPtr == TOP_IDX) |=>
      (stkPtr == TOP_IDX && $stable(topAddr) && ovfFlag && !resetReq)); // R6
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ((popReq || dropReq) && stkPtr == '0) |-> topAddr == '0); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((popReq || dropReq) && stkPtr == '0) |=> (unfFlag && stkPtr == '0)); // R7
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagWrEn) |=> ovfFlag); // R8
endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
  localparam int PW = 5;
  localparam int DW = 21;
  localparam int TOPI = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgOvfRst = 1'b0, cfgUnfRst = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0, dropReq = 1'b0;
  logic tosWrEn = 1'b0, ptrWrEn = 1'b0, flagWrEn = 1'b0;
  logic [DW-1:0] pushPc = '0, tosWrData = '0;
  logic [PW-1:0] ptrWrData = '0;
  logic [1:0] flagWrData = '0;
  logic [DW-1:0] topAddr;
  logic [PW-1:0] stkPtr;
  logic ovfFlag, unfFlag, resetReq;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [1:TOPI];
  logic [DW-1:0] got;

  always #2.5 clk = ~clk;

  ret_addr_stack u0 (
    .clk(clk), .rstN(rstN), .cfgOvfRst(cfgOvfRst), .cfgUnfRst(cfgUnfRst),
    .pushReq(pushReq), .pushPc(pushPc), .popReq(popReq), .dropReq(dropReq),
    .tosWrEn(tosWrEn), .tosWrData(tosWrData), .ptrWrEn(ptrWrEn),
    .ptrWrData(ptrWrData), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .topAddr(topAddr), .stkPtr(stkPtr), .ovfFlag(ovfFlag), .unfFlag(unfFlag),
    .resetReq(resetReq)
  );

  function automatic logic [DW-1:0] val(int i, int salt);
    return DW'(i * 40503 + salt * 977 + 421);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic endCmd();
    @(posedge clk); #1;
    pushReq = 0; popReq = 0; dropReq = 0; tosWrEn = 0; ptrWrEn = 0; flagWrEn = 0;
  endtask

  task automatic doPush(logic [DW-1:0] v);
    @(negedge clk); pushReq = 1; pushPc = v; endCmd();
  endtask

  task automatic doPop(output logic [DW-1:0] v);
    @(negedge clk); popReq = 1; #1 v = topAddr; endCmd();
  endtask

  task automatic doDrop();
    @(negedge clk); dropReq = 1; endCmd();
  endtask

  task automatic doPtr(logic [PW-1:0] p);
    @(negedge clk); ptrWrEn = 1; ptrWrData = p; endCmd();
  endtask

  task automatic doTos(logic [DW-1:0] v);
    @(negedge clk); tosWrEn = 1; tosWrData = v; endCmd();
  endtask

  task automatic doFlag(logic [1:0] d);
    @(negedge clk); flagWrEn = 1; flagWrData = d; endCmd();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(stkPtr == 0, "R1 ptr", stkPtr, 0);
    chk(!ovfFlag && !unfFlag, "R1 flags", {ovfFlag, unfFlag}, 0);
    chk(!resetReq, "R1 resetReq", resetReq, 0);
    chk(topAddr == 0, "R1 top", topAddr, 0);

    // R2 fill with overflow reset disabled
    for (int i = 1; i < TOPI; i++) begin
      model[i] = val(i, 0);
      doPush(model[i]);
      chk(stkPtr == PW'(i), "R2 ptr", stkPtr, i);
      chk(topAddr == model[i], "R2 top", topAddr, model[i]);
      chk(!ovfFlag, "R2 no ovf", ovfFlag, 0);
    end
    // R6 31st push and saturation
    model[TOPI] = val(TOPI, 0);
    doPush(model[TOPI]);
    chk(stkPtr == PW'(TOPI), "R6 ptr 31", stkPtr, TOPI);
    chk(ovfFlag, "R6 ovf", ovfFlag, 1);
    chk(topAddr == model[TOPI], "R6 stored", topAddr, model[TOPI]);
    chk(!resetReq, "R6 no reset", resetReq, 0);
    for (int k = 0; k < 3; k++) begin
      doPush(val(k, 7));
      chk(stkPtr == PW'(TOPI), "R6 sat ptr", stkPtr, TOPI);
      chk(topAddr == model[TOPI], "R6 no overwrite", topAddr, model[TOPI]);
      chk(!resetReq, "R6 no reset", resetReq, 0);
    end

    // R3 pop all, R4 discard in the middle
    for (int i = TOPI; i >= 1; i--) begin
      if (i == 10) begin
        doDrop();
        chk(stkPtr == PW'(i - 1), "R4 ptr", stkPtr, i - 1);
        chk(topAddr == model[i - 1], "R4 top below", topAddr, model[i - 1]);
        i--;
        if (i < 1) break;
      end
      doPop(got);
      chk(got == model[i], "R3 data", got, model[i]);
      chk(stkPtr == PW'(i - 1), "R3 ptr", stkPtr, i - 1);
    end

    // R7 empty pop, underflow reset disabled
    doPop(got);
    chk(got == 0, "R7 zero", got, 0);
    chk(unfFlag && stkPtr == 0, "R7 flag/ptr", {unfFlag, stkPtr}, 6'h20);
    chk(!resetReq, "R7 no reset", resetReq, 0);

    // R8 flag clear semantics (write zero clears)
    doFlag(2'b11);
    chk(ovfFlag && unfFlag, "R8 write one keeps", {ovfFlag, unfFlag}, 3);
    doFlag(2'b10);
    chk(!ovfFlag && unfFlag, "R8 clear ovf only", {ovfFlag, unfFlag}, 1);
    @(negedge clk); popReq = 1; flagWrEn = 1; flagWrData = 2'b00; endCmd();
    chk(unfFlag, "R8 set beats clear", unfFlag, 1);
    chk(!ovfFlag, "R8 ovf cleared", ovfFlag, 0);
    doFlag(2'b00);
    chk(!ovfFlag && !unfFlag, "R8 all clear", {ovfFlag, unfFlag}, 0);

    // R5 overflow with reset enabled
    cfgOvfRst = 1;
    for (int i = 1; i <= TOPI; i++) begin
      model[i] = val(i, 3);
      doPush(model[i]);
    end
    chk(stkPtr == 0, "R5 ptr forced", stkPtr, 0);
    chk(ovfFlag, "R5 ovf", ovfFlag, 1);
    chk(resetReq, "R5 reset", resetReq, 1);
    @(posedge clk); #1;
    chk(!resetReq, "R5 pulse one cycle", resetReq, 0);

    // R9 pointer write, R5 entry 31 stored
    doPtr(PW'(TOPI));
    chk(stkPtr == PW'(TOPI), "R9 load", stkPtr, TOPI);
    chk(topAddr == model[TOPI], "R5 entry 31", topAddr, model[TOPI]);
    for (int p = 1; p <= TOPI; p += 6) begin
      doPtr(PW'(p));
      chk(topAddr == model[p], "R9 entries intact", topAddr, model[p]);
    end

    // R10 top write
    doPtr(5'd4);
    doTos(21'h1ABCDE);
    chk(topAddr == 21'h1ABCDE, "R10 write", topAddr, 21'h1ABCDE);
    chk(stkPtr == 4, "R10 ptr kept", stkPtr, 4);
    doPtr(5'd0);
    doTos(21'h0F0F0);
    chk(topAddr == 0, "R10 ignored at 0", topAddr, 0);
    doPtr(5'd1);
    chk(topAddr == model[1], "R10 entry1 intact", topAddr, model[1]);

    // R7 discard at empty with underflow reset
    cfgUnfRst = 1;
    doPtr(5'd0);
    doFlag(2'b00);
    doDrop();
    chk(unfFlag && stkPtr == 0, "R7 drop underflow", {unfFlag, stkPtr}, 6'h20);
    chk(resetReq, "R7 reset", resetReq, 1);
    @(posedge clk); #1;
    chk(!resetReq, "R7 pulse ends", resetReq, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule